// File: doc/BRIEF.md
# Multi-length round-key generator and store

This block turns a 128-, 192- or 256-bit master key into the full set of 192-bit round keys for the 128-bit lightweight ARX block cipher (add, rotate, xor) and keeps them in a bank of 32 round-key registers. A single generator datapath serves all three key lengths and both cipher directions. It produces one round key per clock cycle and writes each one into the bank as it is made.

After a load strobe the block computes 24, 28 or 32 keys, depending on the key length, and then raises `ready`. The round pipeline reads keys through a combinational port that takes a round index and a direction bit. In the decrypting direction the port reverses the order of the keys. The bank is reused for every data block until the next load. The round transformation and the modes of operation sit outside this block.

Top module: `lea_key_sched`

## Requirements
- R1: `key_len` selects the length at a load. 2'b00 takes `master_key[127:0]` and gives Nr=24. 2'b01 takes `master_key[191:0]` and gives Nr=28. 2'b10 and 2'b11 take all 256 bits and give Nr=32. Master-key word k is `master_key[32k+31:32k]`.
- R2: Key i is produced by the standard cipher schedule. It uses the eight delta constants, indexed by i mod 4, 6 or 8. Each delta is rotated left by i+j. The update is a modular add followed by a left rotation of the state word by 1, 3, 6, 11, 13 or 17. Round-key word m sits in `rd_key[32m+31:32m]`. For 128-bit keys the six words are T0,T1,T2,T1,T3,T1.
- R3: After reset, `ready` is low and `rd_key` is all zero.
- R4: When a load is sampled at clock edge E0, `ready` becomes high after edge E0+Nr, which is one key per cycle.
- R5: `ready` is low in the cycle after any load. A load during generation restarts generation with the new key and length.
- R6: While no load occurs, `ready` stays high and the stored keys stay unchanged, whatever `master_key` and `key_len` do.
- R7: With `rd_dec`=0, `rd_idx`=j returns key j. With `rd_dec`=1 it returns key Nr-1-j. The port is combinational.
- R8: `rd_key` is all zero while `ready` is low or while `rd_idx` ≥ Nr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Strobe that samples the master key and length and starts generation |
| key_len | input | 2 | Key length select |
| master_key | input | 256 | Master key, word k in bits 32k+31:32k |
| rd_idx | input | IDX_W | Round index to read |
| rd_dec | input | 1 | 1 selects reversed (decrypting) order |
| ready | output | 1 | All keys for the current length are stored |
| rd_key | output | 192 | Selected round key |

## Verification
The bench builds the block with its default bank of 32 entries and a 5-bit index. At that size every length fills the bank completely or partially. This brings both the full 256-bit fill and the out-of-range entries of the shorter lengths within reach. The bench sweeps all 32 indices in both directions after each fill. It reloads in the middle of a 256-bit generation with a 128-bit key, and it drives the reserved length code.

// File: rtl/lea_ks_pkg.sv
package lea_ks_pkg;
    localparam int WORD_W      = 32;
    localparam int STATE_WORDS = 8;
    localparam int RK_WORDS    = 6;
    localparam int RK_W        = WORD_W * RK_WORDS;
    localparam int MKEY_W      = WORD_W * STATE_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STATE_WORDS-1:0][WORD_W-1:0] kstate_t;

    typedef enum logic [1:0] {
        KLEN_128 = 2'b00,
        KLEN_192 = 2'b01,
        KLEN_256 = 2'b10,
        KLEN_ALT = 2'b11
    } klen_e;

    function automatic word_t rotl(word_t x, logic [4:0] n);
        logic [2*WORD_W-1:0] w;
        w = {x, x} << n;
        return w[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t delta_k(logic [2:0] k);
        case (k)
            3'd0: return 32'hc3efe9db;
            3'd1: return 32'h44626b02;
            3'd2: return 32'h79e27c8a;
            3'd3: return 32'h78df30ec;
            3'd4: return 32'h715ea49e;
            3'd5: return 32'hc785da0a;
            3'd6: return 32'he04ef22a;
            default: return 32'he5c40957;
        endcase
    endfunction

    function automatic logic [5:0] round_count(klen_e l);
        case (l)
            KLEN_128: return 6'd24;
            KLEN_192: return 6'd28;
            default:  return 6'd32;
        endcase
    endfunction

    function automatic logic [3:0] delta_period(klen_e l);
        case (l)
            KLEN_128: return 4'd4;
            KLEN_192: return 4'd6;
            default:  return 4'd8;
        endcase
    endfunction

    function automatic logic [3:0] key_words(klen_e l);
        case (l)
            KLEN_128: return 4'd4;
            KLEN_192: return 4'd6;
            default:  return 4'd8;
        endcase
    endfunction

    function automatic logic [4:0] lane_shift(int j);
        case (j)
            0: return 5'd1;
            1: return 5'd3;
            2: return 5'd6;
            3: return 5'd11;
            4: return 5'd13;
            default: return 5'd17;
        endcase
    endfunction
endpackage

// File: rtl/lea_ks_round.sv
module lea_ks_round
    import lea_ks_pkg::*;
(
    input  kstate_t          t_i,
    input  logic [4:0]       step_i,
    input  logic [2:0]       dsel_i,
    input  klen_e            len_i,
    output kstate_t          t_o,
    output logic [RK_W-1:0]  rk_o
);
    word_t d;
    logic [RK_WORDS-1:0][WORD_W-1:0] upd;

    assign d = delta_k(dsel_i);

    for (genvar j = 0; j < RK_WORDS; j++) begin : g_lane
        word_t sum;
        assign sum = t_i[j] + rotl(d, step_i + 5'(j));
        if (j < 4) begin : g_always
            assign upd[j] = rotl(sum, lane_shift(j));
        end else begin : g_wide
            assign upd[j] = (len_i == KLEN_128) ? t_i[j] : rotl(sum, lane_shift(j));
        end
    end

    always_comb begin
        t_o = t_i;
        for (int k = 0; k < RK_WORDS; k++) t_o[k] = upd[k];
        if (len_i == KLEN_256 || len_i == KLEN_ALT) begin
            t_o[0] = t_i[6];
            t_o[1] = t_i[7];
            for (int k = 0; k < RK_WORDS; k++) t_o[k+2] = upd[k];
        end
        if (len_i == KLEN_128)
            rk_o = {upd[1], upd[3], upd[1], upd[2], upd[1], upd[0]};
        else
            rk_o = upd;
    end
endmodule

// File: rtl/lea_rk_bank.sv
module lea_rk_bank
    import lea_ks_pkg::*;
#(
    parameter int NUM_RK = 32,
    parameter int IDX_W  = $clog2(NUM_RK),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RK_W-1:0]  wdata,
    input  logic [CNT_W-1:0] nr,
    input  logic             valid,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_dec,
    output logic [RK_W-1:0]  rd_key
);
    logic [RK_W-1:0] mem_q [NUM_RK];
    logic [IDX_W-1:0] phys;
    logic in_range;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_comb begin
        in_range = {1'b0, rd_idx} < nr;
        phys     = rd_dec ? IDX_W'(nr - CNT_W'(1) - {1'b0, rd_idx}) : rd_idx;
        rd_key   = (valid && in_range) ? mem_q[phys] : '0;
    end

    // R1
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < nr));
    // R8
    zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_key != '0) |-> valid);
endmodule

// File: rtl/lea_key_sched.sv
module lea_key_sched
    import lea_ks_pkg::*;
#(
    parameter int NUM_RK = 32,
    parameter int IDX_W  = $clog2(NUM_RK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        key_len,
    input  logic [MKEY_W-1:0] master_key,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_dec,
    output logic              ready,
    output logic [RK_W-1:0]   rd_key
);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        logic             busy;
        logic             ready;
        logic [IDX_W-1:0] cnt;
        logic [2:0]       dsel;
        klen_e            len;
        logic [CNT_W-1:0] nr;
        kstate_t          t;
    } ks_st_t;

    ks_st_t st_d, st_q;
    kstate_t t_next;
    logic [RK_W-1:0] rk_new;
    klen_e len_in;

    assign len_in = klen_e'(key_len);

    lea_ks_round u_round (
        .t_i    (st_q.t),
        .step_i (5'(st_q.cnt)),
        .dsel_i (st_q.dsel),
        .len_i  (st_q.len),
        .t_o    (t_next),
        .rk_o   (rk_new)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.ready = 1'b0;
            st_d.cnt   = '0;
            st_d.dsel  = '0;
            st_d.len   = len_in;
            st_d.nr    = CNT_W'(round_count(len_in));
            for (int k = 0; k < STATE_WORDS; k++)
                st_d.t[k] = (k < int'(key_words(len_in))) ? master_key[WORD_W*k +: WORD_W] : '0;
        end else if (st_q.busy) begin
            st_d.t    = t_next;
            st_d.cnt  = st_q.cnt + IDX_W'(1);
            st_d.dsel = ({1'b0, st_q.dsel} == delta_period(st_q.len) - 4'd1) ? 3'd0 : st_q.dsel + 3'd1;
            if ({1'b0, st_q.cnt} == st_q.nr - CNT_W'(1)) begin
                st_d.busy  = 1'b0;
                st_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, ready: 1'b0, cnt: '0, dsel: '0,
                              len: KLEN_128, nr: '0, t: '0};
        else        st_q <= st_d;
    end

    assign ready = st_q.ready;

    lea_rk_bank #(.NUM_RK(NUM_RK), .IDX_W(IDX_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_q.busy),
        .waddr  (st_q.cnt),
        .wdata  (rk_new),
        .nr     (st_q.nr),
        .valid  (st_q.ready),
        .rd_idx (rd_idx),
        .rd_dec (rd_dec),
        .rd_key (rd_key)
    );

    // R5
    load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready);
    // R6
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !load) |=> ready);
    // R2
    dsel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ({1'b0, st_q.dsel} < delta_period(st_q.len)));
    // R4
    ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(st_q.busy));
endmodule

// File: tb/sim_lea_key_sched.sv
module sim_lea_key_sched;
    logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, rd_dec = 1'b0, ready;
    logic [1:0] key_len = 2'b00;
    logic [255:0] master_key = '0;
    logic [4:0] rd_idx = '0;
    logic [191:0] rd_key;

    always #5 clk = ~clk;

    lea_key_sched u0 (.clk(clk), .rst_n(rst_n), .load(load), .key_len(key_len),
        .master_key(master_key), .rd_idx(rd_idx), .rd_dec(rd_dec),
        .ready(ready), .rd_key(rd_key));

    int checks = 0, fails = 0, sweep = 0, ref_nr = 0, ref_left = 0;
    bit ref_ready = 0, done = 0;
    string tag = "R3";
    logic [191:0] ref_rk [32];
    logic [31:0] dl [8] = '{32'hc3efe9db, 32'h44626b02, 32'h79e27c8a, 32'h78df30ec,
                            32'h715ea49e, 32'hc785da0a, 32'he04ef22a, 32'he5c40957};
    int sh [6] = '{1, 3, 6, 11, 13, 17};

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        n = n % 32;
        return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
    endfunction

    task automatic expand(input logic [1:0] kl, input logic [255:0] mk);
        logic [31:0] T [8];
        int nk = (kl == 2'b00) ? 4 : (kl == 2'b01) ? 6 : 8;
        ref_nr = (kl == 2'b00) ? 24 : (kl == 2'b01) ? 28 : 32;
        for (int k = 0; k < 8; k++) T[k] = (k < nk) ? mk[32*k +: 32] : '0;
        for (int i = 0; i < ref_nr; i++) begin
            if (nk == 4) begin
                for (int j = 0; j < 4; j++) T[j] = rl(T[j] + rl(dl[i % 4], i + j), sh[j]);
                ref_rk[i] = {T[1], T[3], T[1], T[2], T[1], T[0]};
            end else if (nk == 6) begin
                for (int j = 0; j < 6; j++) T[j] = rl(T[j] + rl(dl[i % 6], i + j), sh[j]);
                ref_rk[i] = {T[5], T[4], T[3], T[2], T[1], T[0]};
            end else begin
                for (int j = 0; j < 6; j++) begin
                    int x = (6 * i + j) % 8;
                    T[x] = rl(T[x] + rl(dl[i % 8], i + j), sh[j]);
                end
                for (int m = 0; m < 6; m++) ref_rk[i][32*m +: 32] = T[(6 * i + m) % 8];
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic [191:0] exp_key;
        bit was_load;
        @(posedge clk);
        was_load = load;
        if (!rst_n) begin
            ref_ready = 0; ref_left = 0;
        end else if (was_load) begin
            expand(key_len, master_key);
            ref_ready = 0; ref_left = ref_nr;
        end else if (ref_left > 0) begin
            ref_left--;
            if (ref_left == 0) ref_ready = 1;
        end
        #1;
        load = 1'b0;
        rd_idx = 5'(sweep);
        rd_dec = sweep[5];
        sweep++;
        #2;
        chk(ready == ref_ready, {tag, " ready"}, 192'(ready), 192'(ref_ready));
        if (ref_ready && int'(rd_idx) < ref_nr)
            exp_key = ref_rk[rd_dec ? ref_nr - 1 - int'(rd_idx) : int'(rd_idx)];
        else
            exp_key = '0;
        chk(rd_key === exp_key, {tag, " key"}, rd_key, exp_key);
    endtask

    task automatic do_load(input logic [1:0] kl, input logic [255:0] mk);
        key_len = kl; master_key = mk; load = 1'b1;
        tick();
    endtask

    initial begin
        tag = "R3";
        repeat (3) tick();
        #1 rst_n = 1'b1;
        repeat (3) tick();
        // R1 R2 R4: 128-bit fill, then sweep both directions (R7) and out of range (R8)
        tag = "R4";
        do_load(2'b00, {128'hdeadbeef_cafef00d_01234567_89abcdef, 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0});
        repeat (24) tick();
        tag = "R7";
        repeat (64) tick();
        // R1 R2: 192-bit
        tag = "R1";
        do_load(2'b01, 256'h11111111_22222222_13579bdf_2468ace0_fedcba98_76543210_00112233_44556677);
        repeat (92) tick();
        // R2: 256-bit
        tag = "R2";
        do_load(2'b10, 256'h0f0e0d0c_0b0a0908_07060504_03020100_1f1e1d1c_1b1a1918_17161514_13121110);
        repeat (96) tick();
        // R5: reload mid-generation with a 128-bit key
        tag = "R5";
        do_load(2'b10, {8{32'ha5a5_5a5a}});
        repeat (5) tick();
        do_load(2'b00, 256'h0_0000_0000_0000_0000_0000_0000_3c3c_c3c3_7e7e_e7e7_1818_8181_9999_6666);
        repeat (70) tick();
        // R6: key inputs change without a load
        tag = "R6";
        key_len = 2'b10; master_key = '1;
        repeat (64) tick();
        // R8 and R1: reserved length code behaves as 256-bit
        tag = "R8";
        do_load(2'b11, 256'h0f0e0d0c_0b0a0908_07060504_03020100_1f1e1d1c_1b1a1918_17161514_13121110);
        repeat (80) tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule